// File: doc/BRIEF.md
# Asynchronous Memory Bus Write/Read Cycle Capture

This block sits behind the pins of an asynchronous parallel memory port and turns the host's strobe activity into clean events in a fast system clock domain. Chip select (`ce_n`), write strobe (`we_n`) and output enable (`oe_n`) are sampled through a synchronizer. The address and write-data buses pass through a delay line of the same depth, so bus samples stay aligned with strobe samples.

A write exists only while chip select and write strobe are both low. Either strobe may be the one that opens or closes the cycle. The address is taken when the combined write condition starts, which is at the later of the two falling edges. The data is taken when that condition ends, which is at the earlier of the two rising edges. Each write yields a single `wr_event` pulse that carries the captured address and data.

Reads are reported through `rd_req` and `rd_addr`. A combinational `dout_en` tells the pad logic when it may drive the data bus. Command decoding and the storage array belong to the consumer.

Top module: `bus_cycle_capture`

## Requirements
- R1: After reset, `wr_event` and `rd_req` are 0, and `wr_addr`, `wr_data` and `rd_addr` are all zero.
- R2: Each write cycle, meaning an interval with `ce_n` and `we_n` both low, produces exactly one `wr_event` pulse one clock wide. With the default two synchronizer stages, the pulse is high between the third and fourth rising clock edges after the earlier of the two strobes rises. It is never high while the write is still in progress.
- R3: `wr_addr` equals the value on `addr` when the later of `ce_n`/`we_n` fell. The bus must be held for one clock after that fall. Address changes later in the cycle are ignored.
- R4: `wr_data` equals the value on `wdata` when the earlier of `ce_n`/`we_n` rose. The bus must be held for one clock after that rise. Data present earlier in the cycle is ignored, and `wr_data` changes only in the cycle where `wr_event` is high.
- R5: All four orderings of the strobes are handled the same way: `we_n` or `ce_n` falling first, `we_n` or `ce_n` rising first, and the simultaneous cases.
- R6: `dout_en` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1 at the pins, with no clock involved.
- R7: `rd_req` is 1 while the synchronized pins show `ce_n`=0, `oe_n`=0 and `we_n`=1, lagging the pins by three clock edges. `rd_addr` then carries the address sampled with the same delay and follows address changes during the read.
- R8: While `ce_n` is 1, `we_n` pulses produce no `wr_event`, leave `wr_addr`/`wr_data` unchanged, and `rd_req` stays 0 whatever `oe_n` does.
- R9: With `oe_n` low during a write, the cycle is a write: `rd_req` and `dout_en` stay 0 and the `wr_event` still appears.
- R10: When `we_n` rises while `ce_n` and `oe_n` stay low, `wr_event` and the rising `rd_req` appear in the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus strobes |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip select from the bus, active low, asynchronous |
| we_n | input | 1 | Write strobe from the bus, active low, asynchronous |
| oe_n | input | 1 | Output enable from the bus, active low, asynchronous |
| addr | input | ADDR_W | Address bus |
| wdata | input | DATA_W | Write data bus |
| dout_en | output | 1 | Pad drive enable for read data; the bus floats when 0 |
| rd_req | output | 1 | Read in progress, registered |
| rd_addr | output | ADDR_W | Address of the current read |
| wr_event | output | 1 | One-clock pulse per completed write |
| wr_addr | output | ADDR_W | Address captured at write start |
| wr_data | output | DATA_W | Data captured at write end |

## Verification
Two functions can fall in the same cycle: closing a write and opening a read. They coincide when the host releases `we_n` while chip select and output enable stay low. The bench provokes this directly. It then checks that `wr_event` and `rd_req` rise together on the third edge after the release, with `rd_req` still low one cycle earlier. The captured address and data must still belong to the write. Around this, the bench runs a sweep of every strobe ordering with fall and rise gaps of zero to two cycles. In that sweep the bus value changes mid-cycle, so only correctly timed capture gives the computed expected values.

// File: rtl/bcap_pkg.sv
package bcap_pkg;

  typedef struct packed {
    logic ce;
    logic we;
    logic oe;
  } strobe_t;

  localparam int STROBE_W = $bits(strobe_t);

endpackage

// File: rtl/bcap_rst_sync.sv
module bcap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= 2'b00;
    else        chain <= {chain[0], 1'b1};
  end

  assign rst_sync_n = chain[1];

endmodule

// File: rtl/bcap_pipe.sv
// Delay line used both as strobe synchronizer and as bus alignment stage.
module bcap_pipe #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/bcap_cycle.sv
module bcap_cycle
  import bcap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              wr_event,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr
);

  logic act, act_q;
  logic wr_start, wr_end, rd_now;
  logic addr_en, data_en, rda_en;
  logic [ADDR_W-1:0] wr_addr_nx, rd_addr_nx;
  logic [DATA_W-1:0] wr_data_nx;
  logic              wr_event_nx, rd_req_nx;

  // next-state logic
  always_comb begin
    act         = ~stb.ce & ~stb.we;
    wr_start    = act & ~act_q;
    wr_end      = ~act & act_q;
    rd_now      = ~stb.ce & ~stb.oe & stb.we;
    addr_en     = wr_start;
    data_en     = wr_end;
    rda_en      = rd_now;
    wr_addr_nx  = bus_addr;
    wr_data_nx  = bus_data;
    rd_addr_nx  = bus_addr;
    wr_event_nx = wr_end;
    rd_req_nx   = rd_now;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      wr_event <= 1'b0;
      rd_req   <= 1'b0;
    end else begin
      act_q    <= act;
      wr_event <= wr_event_nx;
      rd_req   <= rd_req_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wr_addr <= '0;
    else if (addr_en) wr_addr <= wr_addr_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wr_data <= '0;
    else if (data_en) wr_data <= wr_data_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_addr <= '0;
    else if (rda_en) rd_addr <= rd_addr_nx;
  end

  // R2: the event never lasts two cycles
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_event |=> !wr_event);

  // R3: address frozen while the write condition persists
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && act) |=> $stable(wr_addr));

  // R4: data register moves only together with the event
  p_data_with_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_data) |-> wr_event);

  // R8: an event implies both strobes were seen low
  p_write_needs_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_event |-> (!$past(stb.ce, 2) && !$past(stb.we, 2)));

endmodule

// File: rtl/bus_cycle_capture.sv
module bus_cycle_capture
  import bcap_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              dout_en,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_event,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam int BUS_W = ADDR_W + DATA_W;

  logic                rst_sync_n;
  strobe_t             raw_stb, sync_stb;
  logic [STROBE_W-1:0] sync_bits;
  logic [BUS_W-1:0]    bus_dly;

  bcap_rst_sync i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign raw_stb = '{ce: ce_n, we: we_n, oe: oe_n};

  bcap_pipe #(
    .W       (STROBE_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({STROBE_W{1'b1}})
  ) i_stb_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (raw_stb),
    .q     (sync_bits)
  );

  assign sync_stb = strobe_t'(sync_bits);

  bcap_pipe #(
    .W       (BUS_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ('0)
  ) i_bus_dly (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({addr, wdata}),
    .q     (bus_dly)
  );

  bcap_cycle #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_cycle (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .stb      (sync_stb),
    .bus_addr (bus_dly[BUS_W-1:DATA_W]),
    .bus_data (bus_dly[DATA_W-1:0]),
    .wr_event (wr_event),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr)
  );

  // R6/R9: pad drive only for a clean read, straight from the pins
  assign dout_en = ~ce_n & ~oe_n & we_n;

endmodule

// File: tb/test_bus_cycle_capture.sv
`timescale 1ns/1ps
module test_bus_cycle_capture;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 8;

  logic clk, rst_n, ce_n, we_n, oe_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic dout_en, rd_req, wr_event;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] wr_data;

  int n_chk = 0, n_fail = 0, ev_cnt = 0;
  bit done = 0;

  bus_cycle_capture #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) i_bus_cycle_capture (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .dout_en(dout_en), .rd_req(rd_req),
    .rd_addr(rd_addr), .wr_event(wr_event), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rst_n && wr_event) ev_cnt++;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint actv, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, actv, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // which: 0 = we_n, 1 = ce_n
  task automatic set_stb(input int which, input logic v);
    if (which == 0) we_n = v; else ce_n = v;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    int idx, ev0;
    logic [AW-1:0] keep_a;
    logic [DW-1:0] keep_d;

    rst_n = 0; ce_n = 1; we_n = 1; oe_n = 1; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1
    chk(wr_event == 0, "R1", "wr_event", wr_event, 0);
    chk(rd_req == 0,   "R1", "rd_req", rd_req, 0);
    chk(wr_addr == 0,  "R1", "wr_addr", wr_addr, 0);
    chk(wr_data == 0,  "R1", "wr_data", wr_data, 0);
    chk(rd_addr == 0,  "R1", "rd_addr", rd_addr, 0);

    // R6: all pin combinations
    for (int p = 0; p < 8; p++) begin
      ce_n = p[0]; we_n = p[1]; oe_n = p[2];
      #1;
      chk(dout_en == (!p[0] && !p[2] && p[1]), "R6", "dout_en", dout_en,
          (!p[0] && !p[2] && p[1]));
    end
    ce_n = 1; we_n = 1; oe_n = 1;
    repeat (5) @(negedge clk);
    ev_cnt = 0;

    // R2 R3 R4 R5: sweep of orderings and gaps
    idx = 0;
    for (int fo = 0; fo < 2; fo++)
      for (int ro = 0; ro < 2; ro++)
        for (int gf = 0; gf < 3; gf++)
          for (int gr = 0; gr < 3; gr++) begin
            a = AW'(idx * 16'h0931 + 16'h0100);
            d = DW'(idx * 37 + 5);
            @(negedge clk);
            addr = a; wdata = ~d;
            set_stb(fo, 0);
            if (gf == 0) set_stb(1 - fo, 0);
            for (int c = 1; c <= gf; c++) begin
              @(negedge clk);
              if (c == gf) set_stb(1 - fo, 0);
            end
            repeat (2) @(negedge clk);
            chk(wr_event == 0, "R2", "early wr_event", wr_event, 0);
            addr = ~a; wdata = d;
            repeat (2) @(negedge clk);
            set_stb(ro, 1);
            if (gr == 0) set_stb(1 - ro, 1);
            for (int c = 1; c <= 5; c++) begin
              @(negedge clk);
              if (c == 2) begin
                chk(wr_event == 0, "R2", "wr_event before latency", wr_event, 0);
                wdata = ~d;
              end
              if (c == 3) begin
                chk(wr_event == 1, "R2", "wr_event pulse", wr_event, 1);
                chk(wr_addr == a, "R3", "wr_addr", wr_addr, a);
                chk(wr_data == d, "R4", "wr_data", wr_data, d);
              end
              if (c == 4) chk(wr_event == 0, "R2", "pulse width", wr_event, 0);
              if (c == gr) set_stb(1 - ro, 1);
            end
            idx++;
          end
    repeat (3) @(negedge clk);
    chk(ev_cnt == 36, "R5", "events over all orderings", ev_cnt, 36);

    // R7: read
    addr = 16'h1234;
    ce_n = 0; oe_n = 0;
    #1 chk(dout_en == 1, "R6", "dout_en read", dout_en, 1);
    @(negedge clk);
    chk(rd_req == 0, "R7", "rd_req latency", rd_req, 0);
    repeat (2) @(negedge clk);
    chk(rd_req == 1, "R7", "rd_req", rd_req, 1);
    chk(rd_addr == 16'h1234, "R7", "rd_addr", rd_addr, 16'h1234);
    addr = 16'hBEEF;
    repeat (3) @(negedge clk);
    chk(rd_addr == 16'hBEEF, "R7", "rd_addr follows", rd_addr, 16'hBEEF);
    oe_n = 1;
    #1 chk(dout_en == 0, "R6", "dout_en oe high", dout_en, 0);
    repeat (3) @(negedge clk);
    chk(rd_req == 0, "R7", "rd_req oe high", rd_req, 0);
    ce_n = 1; oe_n = 0;
    #1 chk(dout_en == 0, "R6", "dout_en ce high", dout_en, 0);
    repeat (4) @(negedge clk);
    chk(rd_req == 0, "R8", "rd_req deselected", rd_req, 0);

    // R8: we pulses with chip deselected
    keep_a = wr_addr; keep_d = wr_data; ev0 = ev_cnt;
    for (int k = 0; k < 3; k++) begin
      addr = AW'(16'h4000 + k); wdata = DW'(8'hC0 + k);
      we_n = 0; repeat (3) @(negedge clk);
      we_n = 1; repeat (3) @(negedge clk);
      chk(rd_req == 0, "R8", "rd_req during we pulses", rd_req, 0);
    end
    repeat (3) @(negedge clk);
    chk(ev_cnt == ev0, "R8", "no event deselected", ev_cnt, ev0);
    chk(wr_addr == keep_a, "R8", "wr_addr kept", wr_addr, keep_a);
    chk(wr_data == keep_d, "R8", "wr_data kept", wr_data, keep_d);
    oe_n = 1;
    repeat (3) @(negedge clk);

    // R9: oe low during a write
    addr = 16'h0A0A; wdata = 8'h5A;
    ce_n = 0; we_n = 0; oe_n = 0;
    #1 chk(dout_en == 0, "R9", "dout_en during write", dout_en, 0);
    repeat (4) @(negedge clk);
    chk(rd_req == 0, "R9", "rd_req during write", rd_req, 0);
    ce_n = 1; we_n = 1;
    for (int c = 1; c <= 4; c++) begin
      @(negedge clk);
      if (c == 3) begin
        chk(wr_event == 1, "R9", "write still seen", wr_event, 1);
        chk(wr_data == 8'h5A, "R9", "wr_data", wr_data, 8'h5A);
      end
      chk(rd_req == 0, "R9", "rd_req after write", rd_req, 0);
    end
    oe_n = 1;
    repeat (3) @(negedge clk);

    // R10: write closes and read opens together
    addr = 16'h7E01; wdata = 8'h11;
    ce_n = 0; we_n = 0;
    repeat (3) @(negedge clk);
    wdata = 8'h99; oe_n = 0;
    repeat (3) @(negedge clk);
    we_n = 1;
    #1 chk(dout_en == 1, "R6", "dout_en after we release", dout_en, 1);
    for (int c = 1; c <= 4; c++) begin
      @(negedge clk);
      if (c == 2) begin
        chk(rd_req == 0, "R10", "rd_req early", rd_req, 0);
        chk(wr_event == 0, "R10", "wr_event early", wr_event, 0);
      end
      if (c == 3) begin
        chk(wr_event == 1, "R10", "wr_event together", wr_event, 1);
        chk(rd_req == 1, "R10", "rd_req together", rd_req, 1);
        chk(wr_addr == 16'h7E01, "R10", "wr_addr", wr_addr, 16'h7E01);
        chk(wr_data == 8'h99, "R10", "wr_data", wr_data, 8'h99);
      end
    end
    ce_n = 1; oe_n = 1;
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule